// File: doc/BRIEF.md
# SWD Link Connect Sequencer

This block brings a target's serial wire debug port out of an unknown state and proves that the link answers. When a connect request arrives it takes the debug clock and data line. It clocks out a line reset of ones, the 16-bit protocol switch word, a second line reset and eight low idle cycles. Then it releases the data line, leaves the clock high and passes control to a separate transaction engine.

Through a level request/acknowledge handshake the engine is asked to perform one read with request byte 0xA5, which is the debug-port identification register. The engine's status becomes the connect result, and on success its read data becomes the reported 32-bit identification value. The link is only declared up after that read succeeds, even if the target was already in serial wire mode before the request. Every pattern bit uses the same programmable half-period as the engine, so one timing setting covers the whole link.

Top module: `swd_connect_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, link_ok, eng_req and swdio_oe are 0, swclk_out is 1 and idcode is 0.
- R2: The first 64 rising edges of swclk_out after an accepted request each see swdio_out at 1.
- R3: Rising edges 64 to 79 carry the switch word 0xE79E, least significant bit first, so edge 64+i carries bit i of the word.
- R4: Rising edges 80 to 143 each see swdio_out at 1.
- R5: Rising edges 144 to 151 each see swdio_out at 0. Exactly 152 rising edges are produced while swdio_oe is 1.
- R6: While the pattern runs, each low phase and each high phase of swclk_out lasts max(half_period,1) clock cycles. half_period is captured when the request is accepted. swdio_out changes only while swclk_out is low.
- R7: After the last pattern bit, swclk_out is 1 and swdio_oe is 0. eng_req rises with eng_cmd equal to 0xA5 and stays high until eng_ack. eng_req and swdio_oe are never high together.
- R8: In the cycle after eng_ack, done is high for exactly one cycle and link_ok equals the sampled eng_ok. idcode equals eng_rdata when eng_ok is 1 and is 0 otherwise. Both results hold until the next completion.
- R9: busy rises in the cycle after a request is accepted and falls in the same cycle that done rises. A connect_req seen while busy is 1 has no effect, and this includes the cycle in which eng_ack is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| connect_req | input | 1 | Start a connect sequence when not busy |
| half_period | input | 8 | Clock cycles per half bit; 0 acts as 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| link_ok | output | 1 | Result of the last connect |
| idcode | output | 32 | Identification value from the last successful connect |
| swclk_out | output | 1 | Debug clock while the pattern runs |
| swdio_out | output | 1 | Data value while the pattern runs |
| swdio_oe | output | 1 | Data line drive enable |
| eng_req | output | 1 | Read request to the transaction engine |
| eng_cmd | output | 8 | Request byte for the engine |
| eng_ack | input | 1 | Engine response valid |
| eng_ok | input | 1 | Engine status, 1 for an OK acknowledge and good parity |
| eng_rdata | input | 32 | Engine read data |

## Verification
The two events that can fall in one cycle are the engine returning its result and a fresh connect request. The bench holds connect_req high in the very cycle it drives eng_ack. The block must complete the current connect, with done, link_ok and idcode correct, and it must not start a second pattern. The bench judges this by watching, for several cycles afterwards, that busy stays low, the clock stays high, the data line stays released and the rising-edge count stays at 152.

// File: rtl/swd_conn_pkg.sv
// Package: shared state type and protocol constants for the connect sequencer.
// Assumes the switch word is sent least significant bit first.
package swd_conn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_READ  = 2'd2
    } conn_state_t;

    localparam logic [7:0]  IDCODE_RD_CMD = 8'hA5;
    localparam logic [15:0] SWITCH_WORD   = 16'hE79E;
    localparam int          SWITCH_BITS   = 16;

endpackage

// File: rtl/swd_conn_timer.sv
// Module: half-period timer for the debug clock.
// Counts each phase for max(half_period,1) cycles, starting with a low phase.
// Assumes run drops for at least one cycle between sequences, which clears it.
module swd_conn_timer #(
    parameter int HPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [HPW-1:0] half_period,
    output logic           phase_high,
    output logic           bit_done
);
    logic [HPW-1:0] cnt;
    logic [HPW-1:0] hp_eff;
    logic           terminal;

    // Purpose: map a zero half-period onto one cycle and find the phase end.
    always_comb begin
        hp_eff   = (half_period == '0) ? HPW'(1) : half_period;
        terminal = (cnt == hp_eff - HPW'(1));
        bit_done = run && terminal && phase_high;
    end

    // Purpose: advance the phase counter and toggle the clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt        <= '0;
            phase_high <= 1'b0;
        end else if (terminal) begin
            cnt        <= '0;
            phase_high <= ~phase_high;
        end else begin
            cnt        <= cnt + HPW'(1);
        end
    end
endmodule

// File: rtl/swd_conn_pattern.sv
// Module: maps a pattern bit index onto the data value to drive.
// Layout: reset ones, switch word, reset ones, idle zeros.
// Assumes the index never exceeds TOTAL-1 while in use.
module swd_conn_pattern
    import swd_conn_pkg::*;
#(
    parameter int LR_BITS   = 64,
    parameter int IDLE_BITS = 8,
    parameter int IDXW      = 8
) (
    input  logic [IDXW-1:0] bit_idx,
    output logic            data_bit,
    output logic            last_bit
);
    localparam int SW_START   = LR_BITS;
    localparam int LR2_START  = SW_START + SWITCH_BITS;
    localparam int IDLE_START = LR2_START + LR_BITS;
    localparam int TOTAL      = IDLE_START + IDLE_BITS;

    int idx;

    // Purpose: select the data value for the current bit position.
    always_comb begin
        idx = int'(bit_idx);
        if (idx < SW_START) begin
            data_bit = 1'b1;
        end else if (idx < LR2_START) begin
            data_bit = SWITCH_WORD[(idx - SW_START) % SWITCH_BITS];
        end else if (idx < IDLE_START) begin
            data_bit = 1'b1;
        end else begin
            data_bit = 1'b0;
        end
        last_bit = (idx == TOTAL - 1);
    end
endmodule

// File: rtl/swd_conn_ctrl.sv
// Module: connect control state machine.
// Accepts a request when idle, steps through the pattern bits, then holds a
// read request to the engine and records the result.
// Assumes eng_ack is a one-cycle pulse answering eng_req.
module swd_conn_ctrl
    import swd_conn_pkg::*;
#(
    parameter int HPW  = 8,
    parameter int IDXW = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            connect_req,
    input  logic [HPW-1:0]  half_period,
    input  logic            bit_done,
    input  logic            last_bit,
    input  logic            eng_ack,
    input  logic            eng_ok,
    input  logic [DW-1:0]   eng_rdata,
    output conn_state_t     state,
    output logic [IDXW-1:0] bit_idx,
    output logic [HPW-1:0]  hp_q,
    output logic            done,
    output logic            link_ok,
    output logic [DW-1:0]   idcode
);
    // Purpose: sequence the idle, shift and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            hp_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    bit_idx <= '0;
                    if (connect_req) begin
                        hp_q  <= half_period;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (bit_done) begin
                        if (last_bit) begin
                            state <= ST_READ;
                        end else begin
                            bit_idx <= bit_idx + IDXW'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (eng_ack) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture the engine result and raise the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            link_ok <= 1'b0;
            idcode  <= '0;
        end else begin
            done <= (state == ST_READ) && eng_ack;
            if ((state == ST_READ) && eng_ack) begin
                link_ok <= eng_ok;
                idcode  <= eng_ok ? eng_rdata : '0;
            end
        end
    end
endmodule

// File: rtl/swd_connect_seq.sv
// Module: top of the connect sequencer.
// Drives the clock and data line only while the switch pattern runs, then
// hands the link to the transaction engine for one identification read.
// Assumes the engine uses the same half-period setting.
module swd_connect_seq
    import swd_conn_pkg::*;
#(
    parameter int HPW       = 8,
    parameter int DW        = 32,
    parameter int LR_BITS   = 64,
    parameter int IDLE_BITS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           connect_req,
    input  logic [HPW-1:0] half_period,
    output logic           busy,
    output logic           done,
    output logic           link_ok,
    output logic [DW-1:0]  idcode,
    output logic           swclk_out,
    output logic           swdio_out,
    output logic           swdio_oe,
    output logic           eng_req,
    output logic [7:0]     eng_cmd,
    input  logic           eng_ack,
    input  logic           eng_ok,
    input  logic [DW-1:0]  eng_rdata
);
    localparam int TOTAL = 2 * LR_BITS + SWITCH_BITS + IDLE_BITS;
    localparam int IDXW  = $clog2(TOTAL);

    conn_state_t     state;
    logic [IDXW-1:0] bit_idx;
    logic [HPW-1:0]  hp_q;
    logic            phase_high;
    logic            bit_done;
    logic            data_bit;
    logic            last_bit;
    logic            shifting;

    swd_conn_ctrl #(.HPW(HPW), .IDXW(IDXW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .connect_req (connect_req),
        .half_period (half_period),
        .bit_done    (bit_done),
        .last_bit    (last_bit),
        .eng_ack     (eng_ack),
        .eng_ok      (eng_ok),
        .eng_rdata   (eng_rdata),
        .state       (state),
        .bit_idx     (bit_idx),
        .hp_q        (hp_q),
        .done        (done),
        .link_ok     (link_ok),
        .idcode      (idcode)
    );

    swd_conn_timer #(.HPW(HPW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (shifting),
        .half_period (hp_q),
        .phase_high  (phase_high),
        .bit_done    (bit_done)
    );

    swd_conn_pattern #(.LR_BITS(LR_BITS), .IDLE_BITS(IDLE_BITS), .IDXW(IDXW)) u_pat (
        .bit_idx  (bit_idx),
        .data_bit (data_bit),
        .last_bit (last_bit)
    );

    // Purpose: drive the line pins and the engine request from the state.
    always_comb begin
        shifting  = (state == ST_SHIFT);
        busy      = (state != ST_IDLE);
        swclk_out = !(shifting && !phase_high);
        swdio_oe  = shifting;
        swdio_out = shifting && data_bit;
        eng_req   = (state == ST_READ);
        eng_cmd   = IDCODE_RD_CMD;
    end
endmodule

// File: rtl/swd_connect_seq_chk.sv
// Module: property checker for the connect sequencer, bound to the top.
// Assumes synchronous active-low reset.
module swd_connect_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic connect_req,
    input logic busy,
    input logic done,
    input logic swclk_out,
    input logic swdio_out,
    input logic swdio_oe,
    input logic eng_req,
    input logic eng_ack
);
    a_r1_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        !swdio_oe |-> swclk_out);

    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (swdio_oe && swclk_out && $past(swdio_oe && swclk_out)) |-> $stable(swdio_out));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        swdio_oe |-> !eng_req);

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> eng_req);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !connect_req) |=> !busy);
endmodule

bind swd_connect_seq swd_connect_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .connect_req (connect_req),
    .busy        (busy),
    .done        (done),
    .swclk_out   (swclk_out),
    .swdio_out   (swdio_out),
    .swdio_oe    (swdio_oe),
    .eng_req     (eng_req),
    .eng_ack     (eng_ack)
);

// File: tb/swd_connect_seq_bench.sv
module swd_connect_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        connect_req;
    logic [7:0]  half_period;
    logic        busy, done, link_ok;
    logic [31:0] idcode;
    logic        swclk_out, swdio_out, swdio_oe, eng_req;
    logic [7:0]  eng_cmd;
    logic        eng_ack, eng_ok;
    logic [31:0] eng_rdata;

    always #10 clk = ~clk;

    swd_connect_seq u_swd_connect_seq (
        .clk(clk), .rst_n(rst_n), .connect_req(connect_req), .half_period(half_period),
        .busy(busy), .done(done), .link_ok(link_ok), .idcode(idcode),
        .swclk_out(swclk_out), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_ack(eng_ack), .eng_ok(eng_ok),
        .eng_rdata(eng_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Line monitor, sampled away from the active edge
    int   edge_cnt, low_len, high_len, low_min, low_max, high_min, high_max, unstable;
    logic rx_bits [0:255];
    logic prev_clk = 1'b1;
    logic held;

    task automatic mon_clear();
        edge_cnt = 0; low_len = 0; high_len = 0; unstable = 0;
        low_min = 1000; low_max = 0; high_min = 1000; high_max = 0;
    endtask

    always @(negedge clk) begin
        if (swdio_oe) begin
            if (swclk_out) begin
                if (!prev_clk) begin
                    if (edge_cnt < 256) rx_bits[edge_cnt] = swdio_out;
                    held = swdio_out;
                    edge_cnt++;
                    if (low_len < low_min) low_min = low_len;
                    if (low_len > low_max) low_max = low_len;
                    low_len  = 0;
                    high_len = 1;
                end else begin
                    high_len++;
                    if (swdio_out !== held) unstable++;
                end
            end else begin
                if (prev_clk && high_len > 0) begin
                    if (high_len < high_min) high_min = high_len;
                    if (high_len > high_max) high_max = high_len;
                end
                high_len = 0;
                low_len++;
            end
        end
        prev_clk = swclk_out;
    end

    function automatic logic exp_bit(input int i);
        logic [15:0] w = 16'hE79E;
        if (i < 64)  return 1'b1;
        if (i < 80)  return w[i-64];
        if (i < 144) return 1'b1;
        return 1'b0;
    endfunction

    // Vector: {half_period[7:0], ok, ack_delay[3:0], rdata[31:0]}
    localparam int NV = 4;
    localparam logic [44:0] VECS [NV] = '{
        {8'd3, 1'b1, 4'd2, 32'h2BA01477},
        {8'd1, 1'b0, 4'd0, 32'hDEADBEEF},
        {8'd0, 1'b1, 4'd5, 32'h0BC11477},
        {8'd2, 1'b1, 4'd0, 32'h12345678}
    };

    task automatic run_case(input logic [7:0] hp, input logic ok, input int dly,
                            input logic [31:0] rd, input bit mid_req, input bit req_with_ack);
        int exp_hp = (hp == 0) ? 1 : int'(hp);
        int m2 = 0, m3 = 0, m4 = 0, m5 = 0, hold_err = 0;
        mon_clear();
        @(negedge clk);
        half_period = hp; connect_req = 1'b1;
        @(negedge clk);
        connect_req = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        half_period = 8'd7;  // later changes must not matter
        while (!eng_req) begin
            @(negedge clk);
            connect_req = mid_req && (edge_cnt == 40);
        end
        connect_req = 1'b0;
        for (int i = 0; i < 152; i++) begin
            if (rx_bits[i] !== exp_bit(i)) begin
                if (i < 64) m2++; else if (i < 80) m3++; else if (i < 144) m4++; else m5++;
            end
        end
        chk(m2 == 0, "R2", "first reset ones mismatches", m2, 0);
        chk(m3 == 0, "R3", "switch word mismatches", m3, 0);
        chk(m4 == 0, "R4", "second reset ones mismatches", m4, 0);
        chk(m5 == 0, "R5", "idle zero mismatches", m5, 0);
        chk(edge_cnt == 152, "R5", "rising edge count", edge_cnt, 152);
        chk(low_min == exp_hp && low_max == exp_hp, "R6", "low phase width", low_max, exp_hp);
        chk(high_min == exp_hp && high_max == exp_hp, "R6", "high phase width", high_max, exp_hp);
        chk(unstable == 0, "R6", "data change while clock high", unstable, 0);
        chk(swclk_out == 1'b1 && swdio_oe == 1'b0, "R7", "line released clock high",
            {swclk_out, swdio_oe}, 2'b10);
        chk(eng_cmd == 8'hA5, "R7", "request byte", eng_cmd, 8'hA5);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            if (!eng_req) hold_err++;
        end
        chk(hold_err == 0, "R7", "eng_req held until ack", hold_err, 0);
        eng_ack = 1'b1; eng_ok = ok; eng_rdata = rd; connect_req = req_with_ack;
        @(negedge clk);
        eng_ack = 1'b0; connect_req = 1'b0; eng_rdata = 32'hFFFF_FFFF;
        chk(done == 1'b1, "R8", "done strobe", done, 1);
        chk(busy == 1'b0, "R9", "busy falls with done", busy, 0);
        chk(link_ok == ok, "R8", "link_ok", link_ok, ok);
        chk(idcode == (ok ? rd : 32'h0), "R8", "idcode", idcode, ok ? rd : 32'h0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", done, 0);
        if (req_with_ack || mid_req) begin
            repeat (10) @(negedge clk);
            chk(busy == 1'b0 && swclk_out == 1'b1 && swdio_oe == 1'b0, "R9",
                "request while busy ignored", {busy, swclk_out, swdio_oe}, 3'b010);
            chk(edge_cnt == 152, "R9", "no second pattern", edge_cnt, 152);
            chk(idcode == (ok ? rd : 32'h0), "R8", "idcode held", idcode, ok ? rd : 32'h0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; connect_req = 1'b0; half_period = 8'd1;
        eng_ack = 1'b0; eng_ok = 1'b0; eng_rdata = '0;
        mon_clear();
        repeat (3) @(negedge clk);
        chk({busy, done, link_ok, eng_req, swdio_oe, swclk_out} == 6'b000001, "R1",
            "outputs in reset", {busy, done, link_ok, eng_req, swdio_oe, swclk_out}, 6'b000001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idcode == 32'h0 && busy == 1'b0, "R1", "state after reset", idcode, 0);

        for (int v = 0; v < NV; v++) begin
            run_case(VECS[v][44:37], VECS[v][36], int'(VECS[v][35:32]), VECS[v][31:0], 1'b0, 1'b0);
        end

        // Requests while busy: mid-pattern and in the same cycle as the result
        run_case(8'd1, 1'b1, 1, 32'hCAFE0001, 1'b1, 1'b1);

        // Reset in the middle of a pattern
        @(negedge clk);
        half_period = 8'd2; connect_req = 1'b1;
        @(negedge clk);
        connect_req = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, link_ok, eng_req, swdio_oe, swclk_out} == 6'b000001, "R1",
            "outputs after mid-pattern reset",
            {busy, done, link_ok, eng_req, swdio_oe, swclk_out}, 6'b000001);
        chk(idcode == 32'h0, "R1", "idcode after reset", idcode, 0);

        finish_run();
    end
endmodule